// File: doc/BRIEF.md
# Paged EEPROM Write Buffer Controller

This controller sits between a byte-wide external-data bus and an on-chip data EEPROM. Bus writes that hit the EEPROM window are collected in a 32-byte page buffer. The low address bits pick the slot, and a mask records which slots hold fresh data. A write made with the load-only control bit clear starts a programming cycle. Only the slots marked as loaded are copied into the array, at the page base taken from that last write. The buffer is then marked empty.

While a cycle is running, the ready/busy status sits low and further writes are refused. A bus read of any byte that is being programmed returns that byte with its top bit inverted, so software can poll for completion. Other addresses read straight from the array. The end of the busy period is timed by an internal counter whose length is a parameter. The array itself is modelled outside the block and reached through a one-byte write port and a combinational read port.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, rdyBusy is 1, writeFail is 0 and arrWe is 0.
- R2: An access reaches the EEPROM only when ctrlEnable is 1 and busAddr is below EE_SIZE. Any other write loads nothing, raises no writeFail and leaves rdyBusy unchanged, and any other read returns 0x00.
- R3: An EEPROM write is accepted only when ctrlWriteEn, ctrlInhibitN and rdyBusy are all 1. A refused write stores nothing and drives writeFail to 1 in the cycle after it is sampled.
- R4: An accepted byte goes to buffer slot busAddr[PAGE_W-1:0]. A second load to the same slot replaces the first.
- R5: An accepted write with ctrlLoadOnly = 1 only fills the buffer: no array write takes place and rdyBusy stays 1.
- R6: An accepted write with ctrlLoadOnly = 0 loads its own byte and then starts programming. rdyBusy is 0 from the next cycle on. The page base is that write's address with its low PAGE_W bits cleared, whatever addresses loaded the other slots.
- R7: Programming writes each loaded slot exactly once, at page base plus slot index, and writes nothing else. Array writes happen only while rdyBusy is 0. After a commit all slots count as empty.
- R8: rdyBusy stays 0 for exactly PROG_CYCLES clock cycles after the commit write is sampled and then returns to 1. PROG_CYCLES must be larger than 2**PAGE_W.
- R9: While busy, a read of a byte being programmed returns its new value with bit 7 inverted. Other reads, and all reads once idle, return the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Bus byte address |
| busWrData | input | 8 | Bus write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe, sampled at each rising edge |
| ctrlEnable | input | 1 | Maps the EEPROM window onto the bus |
| ctrlWriteEn | input | 1 | Allows writes to the EEPROM |
| ctrlInhibitN | input | 1 | Write inhibit, writes allowed when 1 |
| ctrlLoadOnly | input | 1 | 1: fill buffer only; 0: start programming |
| arrRdData | input | 8 | Array read data for arrRdAddr |
| busRdData | output | 8 | Read data returned to the bus |
| rdyBusy | output | 1 | 1 when idle, 0 while programming |
| writeFail | output | 1 | One-cycle flag for a refused write |
| arrWe | output | 1 | Array write enable |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | 8 | Array write data |
| arrRdAddr | output | ADDR_W | Array read address |

## Verification
The bench builds the block with ADDR_W = 16, PAGE_W = 5, EE_SIZE = 1024 and PROG_CYCLES = 40. With a 1 KiB window on a 16-bit bus, addresses just above the window are legal bus values, so the out-of-range case can be driven. A busy period of 40 cycles is longer than the 32-cycle page scan. That leaves room to make polling reads and refused writes in the middle of a cycle and still measure the exact busy length afterwards. Page contents are compared in full against a model of the buffer kept in the bench. This shows that unloaded slots and stale buffer bytes never reach the array.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  // Strobes from the control section to the datapath, one cycle wide unless noted
  typedef struct packed {
    logic sel;      // current bus address falls in the EEPROM window
    logic load;     // accepted write: store byte in its slot
    logic commit;   // accepted write with load-only clear
    logic scanOn;   // level: page scan in progress
    logic progEnd;  // last cycle of the busy period
  } ctrlStrobes_t;

endpackage

// File: rtl/eeprom_pw_ctrl.sv
module eeprom_pw_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int EE_SIZE     = 2048,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              ctrlEnable,
  input  logic              ctrlWriteEn,
  input  logic              ctrlInhibitN,
  input  logic              ctrlLoadOnly,
  output ctrlStrobes_t      strobes,
  output logic [PAGE_W-1:0] scanIdx,
  output logic              rdyBusy,
  output logic              writeFail
);

  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [ADDR_W:0] EE_LIMIT = (ADDR_W+1)'(EE_SIZE);

  logic              ready;
  logic              failQ;
  logic              scanOnQ;
  logic [PAGE_W-1:0] scanIdxQ;
  logic [CNT_W-1:0]  progCnt;

  logic eeSel, wrHit, accept, commit, progEnd;

  always_comb begin
    eeSel   = ctrlEnable && ({1'b0, busAddr} < EE_LIMIT);
    wrHit   = busWr && eeSel;
    accept  = wrHit && ctrlWriteEn && ctrlInhibitN && ready;
    commit  = accept && !ctrlLoadOnly;
    progEnd = !ready && (progCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready    <= 1'b1;
      failQ    <= 1'b0;
      scanOnQ  <= 1'b0;
      scanIdxQ <= '0;
      progCnt  <= '0;
    end else begin
      failQ <= wrHit && !accept;
      if (commit) begin
        ready    <= 1'b0;
        progCnt  <= CNT_W'(PROG_CYCLES - 1);
        scanOnQ  <= 1'b1;
        scanIdxQ <= '0;
      end else begin
        if (!ready) begin
          if (progCnt == '0) ready <= 1'b1;
          else               progCnt <= progCnt - 1'b1;
        end
        if (scanOnQ) begin
          if (&scanIdxQ) scanOnQ <= 1'b0;
          scanIdxQ <= scanIdxQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.sel     = eeSel;
    strobes.load    = accept;
    strobes.commit  = commit;
    strobes.scanOn  = scanOnQ;
    strobes.progEnd = progEnd;
  end

  assign scanIdx   = scanIdxQ;
  assign rdyBusy   = ready;
  assign writeFail = failQ;

endmodule

// File: rtl/eeprom_pw_data.sv
module eeprom_pw_data
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busRd,
  input  ctrlStrobes_t      strobes,
  input  logic [PAGE_W-1:0] scanIdx,
  input  logic [7:0]        arrRdData,
  output logic [7:0]        busRdData,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData
);

  localparam int SLOTS = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [7:0]       pageBuf [SLOTS];
  logic [SLOTS-1:0] validMask;
  logic [SLOTS-1:0] scanMask;
  logic [SLOTS-1:0] pollMask;
  logic [PG_W-1:0]  pollPage;

  logic [PAGE_W-1:0] slot;
  logic [PG_W-1:0]   page;
  logic [SLOTS-1:0]  slotBit;
  logic              polled;

  always_comb begin
    slot    = busAddr[PAGE_W-1:0];
    page    = busAddr[ADDR_W-1:PAGE_W];
    slotBit = SLOTS'(1) << slot;
  end

  // One byte register per slot, written only by an accepted bus write
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobes.load && (slot == PAGE_W'(g))) pageBuf[g] <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      scanMask  <= '0;
      pollMask  <= '0;
      pollPage  <= '0;
    end else begin
      if (strobes.commit) begin
        validMask <= '0;
        scanMask  <= validMask | slotBit;
        pollMask  <= validMask | slotBit;
        pollPage  <= page;
      end else begin
        if (strobes.load)    validMask <= validMask | slotBit;
        if (strobes.progEnd) pollMask  <= '0;
      end
    end
  end

  always_comb begin
    arrWe   = strobes.scanOn && scanMask[scanIdx];
    arrAddr = {pollPage, scanIdx};
    arrData = pageBuf[scanIdx];
  end

  always_comb begin
    polled = pollMask[slot] && (page == pollPage);
    if (!(busRd && strobes.sel)) busRdData = 8'h00;
    else if (polled)             busRdData = pageBuf[slot] ^ 8'h80;
    else                         busRdData = arrRdData;
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int EE_SIZE     = 2048,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              ctrlEnable,
  input  logic              ctrlWriteEn,
  input  logic              ctrlInhibitN,
  input  logic              ctrlLoadOnly,
  input  logic [7:0]        arrRdData,
  output logic [7:0]        busRdData,
  output logic              rdyBusy,
  output logic              writeFail,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic [ADDR_W-1:0] arrRdAddr
);

  ctrlStrobes_t      strobes;
  logic [PAGE_W-1:0] scanIdx;

  eeprom_pw_ctrl #(
    .ADDR_W(ADDR_W), .EE_SIZE(EE_SIZE), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .ctrlEnable(ctrlEnable), .ctrlWriteEn(ctrlWriteEn),
    .ctrlInhibitN(ctrlInhibitN), .ctrlLoadOnly(ctrlLoadOnly),
    .strobes(strobes), .scanIdx(scanIdx), .rdyBusy(rdyBusy), .writeFail(writeFail)
  );

  eeprom_pw_data #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .strobes(strobes), .scanIdx(scanIdx), .arrRdData(arrRdData),
    .busRdData(busRdData), .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  assign arrRdAddr = busAddr;

endmodule

// File: rtl/eeprom_page_writer_checker.sv
module eeprom_page_writer_checker #(
  parameter int ADDR_W  = 16,
  parameter int EE_SIZE = 2048
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              ctrlEnable,
  input logic              ctrlLoadOnly,
  input logic              rdyBusy,
  input logic              writeFail,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr
);

  localparam logic [ADDR_W:0] EE_LIMIT = (ADDR_W+1)'(EE_SIZE);

  logic eeHit;
  assign eeHit = ctrlEnable && ({1'b0, busAddr} < EE_LIMIT);

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> !rdyBusy); // R7

  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    writeFail |-> $past(busWr)); // R3

  AST_BUSY_WRITE_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && eeHit && !rdyBusy) |=> writeFail); // R3

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusy) |-> $past(busWr && eeHit && !ctrlLoadOnly)); // R6

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> ({1'b0, arrAddr} < EE_LIMIT)); // R6

  AST_OUTSIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !eeHit && rdyBusy) |=> (rdyBusy && !writeFail)); // R2

endmodule

bind eeprom_page_writer eeprom_page_writer_checker #(
  .ADDR_W(ADDR_W), .EE_SIZE(EE_SIZE)
) u_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .ctrlEnable(ctrlEnable), .ctrlLoadOnly(ctrlLoadOnly), .rdyBusy(rdyBusy),
  .writeFail(writeFail), .arrWe(arrWe), .arrAddr(arrAddr)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;

  localparam int ADDR_W = 16;
  localparam int PAGE_W = 5;
  localparam int EE     = 1024;
  localparam int PROG   = 40;
  localparam int SLOTS  = 1 << PAGE_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0]        busWrData = '0;
  logic              busRd = 1'b0, busWr = 1'b0;
  logic              ctrlEnable = 1'b1, ctrlWriteEn = 1'b1;
  logic              ctrlInhibitN = 1'b1, ctrlLoadOnly = 1'b1;
  logic [7:0]        arrRdData;
  logic [7:0]        busRdData;
  logic              rdyBusy, writeFail, arrWe;
  logic [ADDR_W-1:0] arrAddr, arrRdAddr;
  logic [7:0]        arrData;

  logic [7:0] mem    [EE];
  logic [7:0] expMem [EE];
  logic [7:0] pendData [SLOTS];
  bit         pendValid [SLOTS];
  int checks = 0, errors = 0, weCount = 0;

  always #4 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .EE_SIZE(EE), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG)
  ) u_eeprom_page_writer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .ctrlEnable(ctrlEnable),
    .ctrlWriteEn(ctrlWriteEn), .ctrlInhibitN(ctrlInhibitN),
    .ctrlLoadOnly(ctrlLoadOnly), .arrRdData(arrRdData), .busRdData(busRdData),
    .rdyBusy(rdyBusy), .writeFail(writeFail), .arrWe(arrWe), .arrAddr(arrAddr),
    .arrData(arrData), .arrRdAddr(arrRdAddr)
  );

  // Array model
  assign arrRdData = (int'(arrRdAddr) < EE) ? mem[int'(arrRdAddr)] : 8'h00;
  always @(posedge clk) begin
    if (rstN && arrWe) begin
      if (int'(arrAddr) < EE) mem[int'(arrAddr)] <= arrData;
      weCount = weCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Model of an accepted write, derived from the requirements
  task automatic modelAccept(input int addr, input int data, input bit loadOnly);
    int slot = addr % SLOTS;
    int base = addr - slot;
    pendData[slot]  = data[7:0];
    pendValid[slot] = 1'b1;
    if (!loadOnly) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (pendValid[s]) expMem[base + s] = pendData[s];
        pendValid[s] = 1'b0;
      end
    end
  endtask

  task automatic busWrite(input int addr, input int data, input bit loadOnly);
    @(negedge clk);
    busAddr = addr[ADDR_W-1:0];
    busWrData = data[7:0];
    ctrlLoadOnly = loadOnly;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busReadChk(input string req, input int addr, input int expv);
    @(negedge clk);
    busAddr = addr[ADDR_W-1:0];
    busRd = 1'b1;
    #1;
    check(req, busRdData, expv);
    busRd = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (!rdyBusy && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic comparePage(input string req, input int base);
    for (int s = 0; s < SLOTS; s++) check(req, mem[base + s], expMem[base + s]);
  endtask

  task automatic testReset;
    check("R1 rdyBusy", rdyBusy, 1);
    check("R1 writeFail", writeFail, 0);
    check("R1 arrWe", arrWe, 0);
    busReadChk("R9 idle read", 5, expMem[5]);
  endtask

  task automatic testRouting;
    int start = weCount;
    ctrlEnable = 1'b0;
    busWrite(16'h4A, 8'h11, 1'b0);
    check("R2 disabled no fail", writeFail, 0);
    check("R2 disabled no busy", rdyBusy, 1);
    busReadChk("R2 disabled read", 16'h4A, 0);
    ctrlEnable = 1'b1;
    busWrite(EE + 3, 8'h22, 1'b0);
    check("R2 above window no fail", writeFail, 0);
    check("R2 above window no busy", rdyBusy, 1);
    busReadChk("R2 above window read", EE + 3, 0);
    repeat (3) @(negedge clk);
    check("R2 no array write", weCount - start, 0);
  endtask

  task automatic testGating;
    int start = weCount;
    int cyc;
    ctrlWriteEn = 1'b0;
    busWrite(16'h41, 8'h33, 1'b1);
    check("R3 writeEn low fails", writeFail, 1);
    ctrlWriteEn = 1'b1;
    ctrlInhibitN = 1'b0;
    busWrite(16'h42, 8'h44, 1'b1);
    check("R3 inhibit fails", writeFail, 1);
    ctrlInhibitN = 1'b1;
    busWrite(16'h40, 8'h55, 1'b0);
    modelAccept(16'h40, 8'h55, 1'b0);
    check("R3 accepted no fail", writeFail, 0);
    check("R6 busy after commit", rdyBusy, 0);
    waitIdle(cyc);
    check("R3 refused bytes not written", weCount - start, 1);
    comparePage("R3 page 0x40", 16'h40);
  endtask

  task automatic testPartialPage;
    int start = weCount;
    int cyc;
    busWrite(16'h100, 8'hA1, 1'b1); modelAccept(16'h100, 8'hA1, 1'b1);
    busWrite(16'h103, 8'h13, 1'b1); modelAccept(16'h103, 8'h13, 1'b1);
    busWrite(16'h11F, 8'hF1, 1'b1); modelAccept(16'h11F, 8'hF1, 1'b1);
    busWrite(16'h103, 8'h3C, 1'b1); modelAccept(16'h103, 8'h3C, 1'b1);
    check("R5 load only stays ready", rdyBusy, 1);
    check("R5 load only no array write", weCount - start, 0);
    busWrite(16'h107, 8'h77, 1'b0); modelAccept(16'h107, 8'h77, 1'b0);
    check("R6 commit drops ready", rdyBusy, 0);
    busReadChk("R9 poll overwritten slot", 16'h103, expMem[16'h103] ^ 8'h80);
    busReadChk("R9 poll commit byte", 16'h107, expMem[16'h107] ^ 8'h80);
    busReadChk("R9 unloaded byte reads array", 16'h105, expMem[16'h105]);
    busWrite(16'h108, 8'h99, 1'b1);
    check("R3 write while busy fails", writeFail, 1);
    waitIdle(cyc);
    check("R7 four slots written", weCount - start, 4);
    comparePage("R7 page 0x100", 16'h100);
    check("R4 overwrite kept last", mem[16'h103], 8'h3C);
    busReadChk("R9 idle read after program", 16'h103, 8'h3C);
  endtask

  task automatic testCrossPage;
    int start = weCount;
    int cyc;
    busWrite(16'h202, 8'h2B, 1'b1); modelAccept(16'h202, 8'h2B, 1'b1);
    busWrite(16'h0A5, 8'h5A, 1'b0); modelAccept(16'h0A5, 8'h5A, 1'b0);
    waitIdle(cyc);
    check("R6 two slots written", weCount - start, 2);
    check("R6 slot lands on commit page", mem[16'hA2], 8'h2B);
    comparePage("R6 page 0xA0", 16'hA0);
    comparePage("R6 page 0x200 untouched", 16'h200);
  endtask

  task automatic testBusyLength;
    int start = weCount;
    int cyc;
    busWrite(16'h300, 8'h30, 1'b0); modelAccept(16'h300, 8'h30, 1'b0);
    waitIdle(cyc);
    check("R8 busy length", cyc, PROG);
    check("R8 ready again", rdyBusy, 1);
    check("R7 buffer emptied", weCount - start, 1);
    comparePage("R7 stale slots not written", 16'h300);
  endtask

  initial begin
    for (int i = 0; i < EE; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      expMem[i] = 8'(i) ^ 8'h5A;
    end
    for (int s = 0; s < SLOTS; s++) pendValid[s] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRouting();
    testGating();
    testPartialPage();
    testCrossPage();
    testBusyLength();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule